// File: doc/BRIEF.md
# Serial TDM Highway Port with Frame Offsets

This block is the system-side serial highway of a framer. One bit clock and one frame sync serve it. Each 125 µs frame holds 32, 64 or 128 byte time slots, which matches 2.048, 4.096 or 8.192 Mbit/s. The port converts parallel bytes into a serial stream on the transmit side and turns the serial stream back into bytes on the receive side. Every byte carries its slot number.

The block places frame start at a programmable distance after the frame sync. That distance has three parts: a byte offset, whose useful range depends on the rate; a bit offset; and a half-bit offset. A control bit selects which phase of the bit period samples the frame sync. The block runs on a clock at twice the bit rate. Each bit period therefore spans two clock cycles: a launch half and a sample half. A free-running phase toggle stands in for the rising and falling edges of the bit clock.

A frame sync that agrees with the running count changes nothing. A frame sync at any other place realigns the counters at once and gives a one-cycle resync pulse.

Top module: `tdm_highway_port`

## Requirements
- R1: While rst_n is low, txd, rx_valid and resync are 0 and the frame position is 0. After release, the position advances by one half-bit per clock.
- R2: rate_sel selects the frame length: 0 gives 32 slots, 1 gives 64 slots, and 2 or 3 give 128 slots. Each slot lasts 16 clocks. With no frame sync, slot 0 recurs every slots×16 clocks.
- R3: Call the clock edge that samples the frame sync E. Frame start (slot 0, bit 0, first half) begins at edge E + 2×(8×byte_off + bit_off) + half_off, where bit_off runs from 0 to 7.
- R4: A byte_off value at or above the slot count of the selected rate is taken modulo the slot count.
- R5: half_off = 1 delays frame start and all launch and sample points by one clock, which is half a bit period.
- R6: phase toggles every clock and is 0 at the first edge after reset. fsync is sampled only on edges where phase equals fs_edge. So fs_edge = 1 samples one clock later than fs_edge = 0.
- R7: txd sends each slot byte most significant bit first. Each bit is held for two clocks and is registered, so it is valid in the cycle its position is current.
- R8: tx_fetch is high in the cycle before a slot's first half-bit. tx_fetch_slot gives that slot. tx_byte is captured at that edge.
- R9: rxd is sampled in the second half of each bit. When the last bit of a slot has been taken, rx_byte and rx_slot are presented with rx_valid high for one cycle.
- R10: A sampled frame sync whose implied position differs from the running count gives a one-cycle resync pulse and a realignment. A sync that matches the count gives no pulse.
- R11: When rate_sel shrinks the frame while the position lies beyond the new frame end, the count wraps to slot 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Frame length select |
| byte_off | input | 7 | Byte offset of frame start |
| bit_off | input | 3 | Bit offset of frame start |
| half_off | input | 1 | Extra half-bit offset |
| fs_edge | input | 1 | Phase on which fsync is sampled |
| fsync | input | 1 | Frame sync, one bit period wide |
| tx_byte | input | 8 | Byte for the slot named by tx_fetch_slot |
| tx_fetch | output | 1 | Transmit byte is being taken |
| tx_fetch_slot | output | 7 | Slot whose byte is taken |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received byte |
| rx_slot | output | 7 | Slot of the received byte |
| resync | output | 1 | Realignment pulse |

## Verification
The bench builds the port with its default parameters: a 7-bit slot field and 8-bit slots. With these, all three frame lengths can be selected, and the byte offset reaches 127 as well as values that wrap at the two shorter rates. Directed alignments measure the distance from the frame sync to frame start for each mix of offset and sampling phase. A behavioural model, compared on every clock, covers serial data in both directions, the fetch strobe and resync, along with a matching sync, a misplaced sync and a rate cut in mid-frame.

// File: rtl/tdm_hw_pkg.sv
package tdm_hw_pkg;

    // log2 of the slot count for a rate code; codes above 2 use the longest frame
    function automatic int unsigned slot_shift(input logic [1:0] rate, input int unsigned slot_w);
        int unsigned r;
        r = (rate > 2'd2) ? 2 : int'(rate);
        return slot_w - 2 + r;
    endfunction

endpackage

// File: rtl/tdm_offset_calc.sv
module tdm_offset_calc
    import tdm_hw_pkg::*;
#(
    parameter int unsigned SLOT_W = 7,
    parameter int unsigned BIT_W  = 3,
    localparam int unsigned PHASE_W = BIT_W + 1,
    localparam int unsigned POS_W   = SLOT_W + PHASE_W
) (
    input  logic [1:0]        rate_sel,
    input  logic [SLOT_W-1:0] byte_off,
    input  logic [BIT_W-1:0]  bit_off,
    input  logic              half_off,
    output logic [POS_W-1:0]  last_pos,
    output logic [POS_W-1:0]  load_pos
);
    int unsigned       shift_w;
    logic [SLOT_W-1:0] slot_mask;
    logic [SLOT_W-1:0] byte_wrapped;
    logic [POS_W-1:0]  off_half;
    logic [POS_W:0]    frame_len;

    always_comb begin
        shift_w      = slot_shift(rate_sel, SLOT_W);
        slot_mask    = SLOT_W'((32'd1 << shift_w) - 32'd1);
        byte_wrapped = byte_off & slot_mask;           // R4 modulo slot count
        off_half     = {byte_wrapped, bit_off, half_off};  // R3/R5 offset in half bits
        frame_len    = (POS_W+1)'(1) << (shift_w + PHASE_W);
        last_pos     = POS_W'(frame_len - (POS_W+1)'(1));
        if (off_half == '0) begin
            load_pos = '0;
        end else begin
            load_pos = POS_W'(frame_len - {1'b0, off_half});
        end
    end
endmodule

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
    parameter int unsigned POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             fs_edge,
    input  logic [POS_W-1:0] last_pos,
    input  logic [POS_W-1:0] load_pos,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_d,
    output logic             resync
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             phase;
        logic             resync;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [POS_W-1:0] step_pos;
    logic             sample;

    always_comb begin
        sample    = fsync && (st_q.phase == fs_edge);
        step_pos  = (st_q.pos >= last_pos) ? '0 : st_q.pos + 1'b1;
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        st_d.pos   = sample ? load_pos : step_pos;
        st_d.resync = sample && (load_pos != step_pos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_q  = st_q.pos;
    assign pos_d  = st_d.pos;
    assign resync = st_q.resync;

    // R2: without a sync the count advances by one inside the frame
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sample) && ($past(pos_q) < $past(last_pos)))
            |-> (pos_q == $past(pos_q) + 1'b1));

    // R11: with a steady frame length the position stays inside the frame
    assert_pos_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (last_pos == $past(last_pos))) |-> (pos_q <= last_pos));

    // R10: a resync pulse follows a sampled frame sync
    assert_resync_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> $past(sample));
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
    parameter int unsigned SLOT_W = 7,
    parameter int unsigned BIT_W  = 3,
    localparam int unsigned DATA_W  = 1 << BIT_W,
    localparam int unsigned PHASE_W = BIT_W + 1,
    localparam int unsigned POS_W   = SLOT_W + PHASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos_d,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              fetch,
    output logic [SLOT_W-1:0] fetch_slot,
    output logic              txd
);
    typedef struct packed {
        logic [DATA_W-1:0] cur;
        logic              txd;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [DATA_W-1:0] shifted;
    logic [BIT_W-1:0]  bit_idx;

    always_comb begin
        fetch      = (pos_d[PHASE_W-1:0] == '0);
        fetch_slot = pos_d[POS_W-1:PHASE_W];
        bit_idx    = pos_d[PHASE_W-1:1];
        st_d       = st_q;
        if (fetch) begin
            st_d.cur = tx_byte;
        end
        shifted  = st_d.cur << bit_idx;
        st_d.txd = shifted[DATA_W-1];   // R7 MSB first
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd = st_q.txd;

    // R7: first bit of a fetched byte is its most significant bit
    assert_tx_msb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fetch)) |-> (txd == $past(tx_byte[DATA_W-1])));
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
    parameter int unsigned SLOT_W = 7,
    parameter int unsigned BIT_W  = 3,
    localparam int unsigned DATA_W  = 1 << BIT_W,
    localparam int unsigned PHASE_W = BIT_W + 1,
    localparam int unsigned POS_W   = SLOT_W + PHASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos_q,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte,
    output logic [SLOT_W-1:0] rx_slot
);
    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [SLOT_W-1:0] slot;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [DATA_W-1:0] next_shift;
    logic              slot_end;

    always_comb begin
        st_d       = st_q;
        next_shift = {st_q.shreg[DATA_W-2:0], rxd};
        slot_end   = &pos_q[PHASE_W-1:0];
        if (pos_q[0]) begin
            st_d.shreg = next_shift;    // R9 sample in second half
        end
        st_d.valid = slot_end;
        if (slot_end) begin
            st_d.data = next_shift;
            st_d.slot = pos_q[POS_W-1:PHASE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_valid = st_q.valid;
    assign rx_byte  = st_q.data;
    assign rx_slot  = st_q.slot;

    // R9: a byte strobe only follows the last half-bit of a slot
    assert_rx_valid_at_slot_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (&$past(pos_q[PHASE_W-1:0])));
endmodule

// File: rtl/tdm_highway_port.sv
module tdm_highway_port #(
    parameter int unsigned SLOT_W = 7,
    parameter int unsigned BIT_W  = 3,
    localparam int unsigned DATA_W  = 1 << BIT_W,
    localparam int unsigned PHASE_W = BIT_W + 1,
    localparam int unsigned POS_W   = SLOT_W + PHASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic [SLOT_W-1:0] byte_off,
    input  logic [BIT_W-1:0]  bit_off,
    input  logic              half_off,
    input  logic              fs_edge,
    input  logic              fsync,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_fetch,
    output logic [SLOT_W-1:0] tx_fetch_slot,
    output logic              txd,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              resync
);
    logic [POS_W-1:0] last_pos;
    logic [POS_W-1:0] load_pos;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;

    tdm_offset_calc #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_offset (
        .rate_sel (rate_sel),
        .byte_off (byte_off),
        .bit_off  (bit_off),
        .half_off (half_off),
        .last_pos (last_pos),
        .load_pos (load_pos)
    );

    tdm_frame_counter #(.POS_W(POS_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .fs_edge  (fs_edge),
        .last_pos (last_pos),
        .load_pos (load_pos),
        .pos_q    (pos_q),
        .pos_d    (pos_d),
        .resync   (resync)
    );

    tdm_tx_ser #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .pos_d      (pos_d),
        .tx_byte    (tx_byte),
        .fetch      (tx_fetch),
        .fetch_slot (tx_fetch_slot),
        .txd        (txd)
    );

    tdm_rx_deser #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_q    (pos_q),
        .rxd      (rxd),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_slot  (rx_slot)
    );
endmodule

// File: tb/tdm_highway_port_tb.sv
`timescale 1ns/1ps
module tdm_highway_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [6:0] byte_off = '0;
    logic [2:0] bit_off = '0;
    logic       half_off = 1'b0;
    logic       fs_edge = 1'b0;
    logic       fsync = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_fetch;
    logic [6:0] tx_fetch_slot;
    logic       txd;
    logic       rxd = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic [6:0] rx_slot;
    logic       resync;

    logic [7:0] tx_tbl [128];
    assign tx_byte = tx_tbl[tx_fetch_slot];

    always #2.5 clk = ~clk;

    tdm_highway_port u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .byte_off(byte_off),
        .bit_off(bit_off), .half_off(half_off), .fs_edge(fs_edge), .fsync(fsync),
        .tx_byte(tx_byte), .tx_fetch(tx_fetch), .tx_fetch_slot(tx_fetch_slot),
        .txd(txd), .rxd(rxd), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_slot(rx_slot), .resync(resync)
    );

    int checks = 0;
    int errors = 0;
    int ecnt = 0;
    int rs_seen = 0;
    logic [15:0] lfsr = 16'hACE1;
    int zq[$];
    // model state
    int m_pos = 0, m_phase = 0, m_rsh = 0, m_cur = 0, m_txd = 0;
    int m_rxv = 0, m_rxb = 0, m_rxs = 0, m_rsy = 0;
    int m_nxt, m_fetch, m_fslot, m_rsy_n;
    int last_fetch, last_fslot;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, ecnt);
        end
    endtask

    function automatic int slots_of(input int r);
        return 32 << ((r > 2) ? 2 : r);
    endfunction

    task automatic model_comb();
        int slots, flen, off, ld, inc, smp;
        slots = slots_of(int'(rate_sel));
        flen  = slots * 16;
        off   = ((int'(byte_off) % slots) * 8 + int'(bit_off)) * 2 + int'(half_off);
        ld    = (off == 0) ? 0 : flen - off;
        inc   = (m_pos >= flen - 1) ? 0 : m_pos + 1;
        smp   = (fsync && (m_phase == int'(fs_edge))) ? 1 : 0;
        m_nxt   = smp ? ld : inc;
        m_rsy_n = (smp && ld != inc) ? 1 : 0;
        m_fetch = (m_nxt % 16 == 0) ? 1 : 0;
        m_fslot = m_nxt / 16;
    endtask

    task automatic step(input logic fs);
        @(negedge clk);
        fsync = fs;
        rxd   = lfsr[0];
        lfsr  = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        #1;
        model_comb();
        last_fetch = int'(tx_fetch);
        last_fslot = int'(tx_fetch_slot);
        chk("R8 fetch", int'(tx_fetch), m_fetch);
        if (m_fetch != 0) chk("R8 fetch slot", int'(tx_fetch_slot), m_fslot);
        @(posedge clk);
        ecnt++;
        if (m_fetch != 0) m_cur = int'(tx_tbl[m_fslot]);
        m_txd = (m_cur >> (7 - ((m_nxt / 2) % 8))) & 1;
        if (m_pos % 2 == 1) m_rsh = ((m_rsh << 1) | int'(rxd)) & 255;
        if (m_pos % 16 == 15) begin
            m_rxv = 1; m_rxb = m_rsh; m_rxs = m_pos / 16;
        end else begin
            m_rxv = 0;
        end
        m_pos = m_nxt;
        m_phase = 1 - m_phase;
        m_rsy = m_rsy_n;
        if (m_pos == 0) zq.push_back(ecnt);
        #1;
        chk("R7 txd", int'(txd), m_txd);
        chk("R9 rx_valid", int'(rx_valid), m_rxv);
        if (m_rxv != 0) begin
            chk("R9 rx_byte", int'(rx_byte), m_rxb);
            chk("R9 rx_slot", int'(rx_slot), m_rxs);
        end
        chk("R10 resync", int'(resync), m_rsy);
        if (resync) rs_seen++;
    endtask

    // sync on an odd edge (phase 0), then measure frame start and period
    task automatic align(input int r, input int b, input int bt, input int h, input int e,
                         input int exp_off, input string tag, output int fs_e);
        int flen, se, first, second;
        rate_sel = 2'(r); byte_off = 7'(b); bit_off = 3'(bt); half_off = 1'(h); fs_edge = 1'(e);
        flen = slots_of(r) * 16;
        if (ecnt % 2 == 1) step(1'b0);
        fs_e = ecnt + 1;
        zq.delete();
        step(1'b1);
        step(1'b1);
        se = fs_e + e;
        while (ecnt < se + exp_off + flen + 2) step(1'b0);
        first = -1; second = -1;
        foreach (zq[i]) begin
            if (zq[i] >= se && first < 0) first = zq[i];
            else if (first >= 0 && second < 0) second = zq[i];
        end
        chk(tag, first - fs_e, e + exp_off);
        chk("R2 frame period", second - first, flen);
    endtask

    initial begin
        int fs_e, base;
        for (int i = 0; i < 128; i++) tx_tbl[i] = 8'((i * 37 + 5) ^ (i << 3));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset txd", int'(txd), 0);
        chk("R1 reset rx_valid", int'(rx_valid), 0);
        chk("R1 reset resync", int'(resync), 0);
        rst_n = 1'b1;
        // R1: count starts from zero after release
        for (int i = 0; i < 40; i++) step(1'b0);

        align(0, 0, 0, 0, 0, 0, "R3 zero offset", fs_e);
        align(1, 5, 3, 1, 1, (5*8+3)*2+1, "R5 R6 half offset falling edge", fs_e);
        align(2, 127, 7, 0, 0, (127*8+7)*2, "R3 max byte offset", fs_e);
        align(0, 40, 2, 0, 1, (8*8+2)*2, "R4 byte offset wrap", fs_e);
        align(1, 70, 0, 1, 0, (6*8)*2+1, "R4 R5 wrap with half", fs_e);

        // R10: correctly placed sync gives no pulse, misplaced gives one
        align(0, 3, 1, 0, 0, (3*8+1)*2, "R3 pre resync", fs_e);
        base = fs_e + 512;
        while (ecnt % 512 != (fs_e - 1) % 512 || ecnt < fs_e + 600) step(1'b0);
        rs_seen = 0;
        step(1'b1); step(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0);
        chk("R10 aligned sync no pulse", rs_seen, 0);
        for (int i = 0; i < 10; i++) step(1'b0);
        rs_seen = 0;
        step(1'b1); step(1'b1);
        for (int i = 0; i < 4; i++) step(1'b0);
        chk("R10 misplaced sync pulse", rs_seen, 1);
        if (base < 0) errors++;

        // R11: shrink frame while position lies beyond the short frame
        rate_sel = 2'd2;
        for (int i = 0; i < 3000; i++) step(1'b0);
        while (m_pos < 700) step(1'b0);
        rate_sel = 2'd0;
        step(1'b0);
        chk("R11 wrap fetch", last_fetch, 1);
        chk("R11 wrap slot", last_fslot, 0);
        for (int i = 0; i < 1100; i++) step(1'b0);

        // R2 rate code 3 behaves as the longest frame
        align(3, 1, 0, 0, 0, 16, "R2 rate code 3", fs_e);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule